// File: doc/BRIEF.md
# Full-Map Home Directory Controller

This block is the home side of a directory coherence scheme for a small shared memory. For every memory block it keeps an exact record of which processors hold a copy (one presence bit each) and whether one of them holds it modified (a single dirty bit). Processors send it read requests and write-ownership requests, each carrying the requester's number and the block index. The controller looks up the block's entry and sends invalidations or recalls to the processors that must give up or downgrade their copy. It collects their acknowledgements, and any writeback data, into its own data array. It then updates the entry and answers the requester with the block's data.

Only one transaction is handled at a time. Outgoing coherence messages leave one per cycle through a valid/ready port, lowest processor number first. Acknowledgements come back on a single input that may carry writeback data. The reply is a one-cycle pulse.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry is empty and clean, `req_ready` is 1, `msg_valid` and `rsp_valid` are 0, and block b holds the data value b.
- R2: A read of a clean block sends no message. It replies with the stored data and adds the requester to the block's sharers.
- R3: A read of a block held dirty by another processor sends a message of kind 1 (recall, keep shared) to the owner only. The owner's acknowledgement data is written to memory and forwarded in the reply. The block becomes clean, with both owner and requester as sharers.
- R4: A write request to a clean block sends a message of kind 0 (invalidate) to every sharer except the requester. Afterwards the block is dirty and the requester is its only holder.
- R5: A write request to a block held dirty by another processor sends a message of kind 2 (recall and invalidate) to the owner. The returned data is stored and forwarded, and the requester becomes the sole dirty owner.
- R6: A request from the block's current dirty owner sends no message and replies with the stored data. A read leaves the entry unchanged.
- R7: The reply is issued only after every acknowledgement owed for the messages of that transaction has arrived.
- R8: `req_ready` is 0 from the cycle after a request is accepted up to and including the reply cycle, so a single transaction is active at a time.
- R9: Messages leave one per accepted cycle, in ascending processor order. A message held with `msg_ready` low keeps its fields.
- R10: Acknowledgements to kind-0 invalidations never change the stored data, whatever value sits on `ack_data`.
- R11: The reply carries the requester's number in `rsp_dst`. `rsp_grant` is 1 for a write-ownership request and 0 for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write-ownership, 0 = read |
| req_id | input | IW | Requesting processor |
| req_blk | input | BW | Block index |
| msg_valid | output | 1 | Coherence message present |
| msg_ready | input | 1 | Network takes the message |
| msg_kind | output | 2 | 0 invalidate, 1 recall keep shared, 2 recall and invalidate |
| msg_dst | output | IW | Target processor |
| msg_blk | output | BW | Block index of the message |
| ack_valid | input | 1 | One acknowledgement arrives |
| ack_data | input | DW | Writeback data for a recall acknowledgement |
| rsp_valid | output | 1 | Reply pulse |
| rsp_dst | output | IW | Processor the reply is for |
| rsp_grant | output | 1 | Reply grants ownership |
| rsp_data | output | DW | Block data |

## Verification
The bench targets the corners where a sloppy controller goes wrong. If the requester is left in the invalidation set, a writer gets invalidated by its own request. If the dirty bit is not cleared after a read recall, a later write recalls a stale owner. If acknowledgements to plain invalidations are written to memory, junk reaches the next reader. A pending counter that drops below the sent count lets the reply overtake a late acknowledgement. Stalls on `msg_ready`, three-way invalidation fans and an owner re-requesting its own block are all driven, followed by a long mixed sequence checked against a model of the directory.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    MSG_INV     = 2'd0,
    MSG_RCL_SHR = 2'd1,
    MSG_RCL_INV = 2'd2
  } msg_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_SEND,
    ST_WAIT,
    ST_REPLY
  } home_st_e;
endpackage

// File: rtl/dir_low_pick.sv
module dir_low_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  mask,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |mask;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dir_store.sv
module dir_store #(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int DW    = 16,
  parameter int BW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    blk,
  output logic [NPROC-1:0] rd_pres,
  output logic             rd_dirty,
  output logic [DW-1:0]    rd_data,
  input  logic             ent_we,
  input  logic [NPROC-1:0] ent_pres,
  input  logic             ent_dirty,
  input  logic             dat_we,
  input  logic [DW-1:0]    dat_in
);
  logic [NBLK-1:0][NPROC-1:0] pres_q;
  logic [NBLK-1:0]            dirty_q;
  logic [NBLK-1:0][DW-1:0]    data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        pres_q[b]  <= '0;
        dirty_q[b] <= 1'b0;
        data_q[b]  <= DW'(b);
      end
    end else begin
      for (int b = 0; b < NBLK; b++) begin
        if (ent_we && (blk == BW'(b))) begin
          pres_q[b]  <= ent_pres;
          dirty_q[b] <= ent_dirty;
        end
        if (dat_we && (blk == BW'(b))) begin
          data_q[b] <= dat_in;
        end
      end
    end
  end

  assign rd_pres  = pres_q[blk];
  assign rd_dirty = dirty_q[blk];
  assign rd_data  = data_q[blk];

  // R4 / R5: a dirty block has exactly one holder
  for (genvar g = 0; g < NBLK; g++) begin : g_chk
    a_r4_dirty_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_q[g] |-> ($countones(pres_q[g]) == 1));
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int  NPROC = 4,
  parameter int  NBLK  = 8,
  parameter int  DW    = 16,
  localparam int IW    = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int BW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [IW-1:0] req_id,
  input  logic [BW-1:0] req_blk,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [1:0]    msg_kind,
  output logic [IW-1:0] msg_dst,
  output logic [BW-1:0] msg_blk,
  input  logic          ack_valid,
  input  logic [DW-1:0] ack_data,
  output logic          rsp_valid,
  output logic [IW-1:0] rsp_dst,
  output logic          rsp_grant,
  output logic [DW-1:0] rsp_data
);
  localparam int CW = $clog2(NPROC + 1);

  home_st_e   st_q, st_d;
  logic [CW-1:0] pend_q, pend_d;
  logic       wr_q, wr_d;
  logic [IW-1:0] id_q, id_d;
  logic [BW-1:0] blk_q, blk_d;
  logic [NPROC-1:0] mask_q, mask_d;
  msg_kind_e  kind_q, kind_d;
  logic       rcl_q, rcl_d;

  logic [NPROC-1:0] e_pres, new_pres, reqbit, tgt, rest;
  logic             e_dirty, new_dirty, ent_we, dat_we;
  logic [DW-1:0]    e_data;
  logic             pk_any;
  logic [IW-1:0]    pk_idx;
  logic             send_fire, ack_take;

  dir_store #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW), .BW(BW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .blk      (blk_q),
    .rd_pres  (e_pres),
    .rd_dirty (e_dirty),
    .rd_data  (e_data),
    .ent_we   (ent_we),
    .ent_pres (new_pres),
    .ent_dirty(new_dirty),
    .dat_we   (dat_we),
    .dat_in   (ack_data)
  );

  dir_low_pick #(.N(NPROC), .IW(IW)) u_pick (
    .mask(mask_q),
    .any (pk_any),
    .idx (pk_idx)
  );

  assign reqbit    = NPROC'(1) << id_q;
  assign tgt       = (wr_q || e_dirty) ? (e_pres & ~reqbit) : '0;
  assign rest      = mask_q & ~(NPROC'(1) << pk_idx);
  assign send_fire = (st_q == ST_SEND) && pk_any && msg_ready;
  assign ack_take  = ack_valid && (pend_q != '0) &&
                     ((st_q == ST_SEND) || (st_q == ST_WAIT));
  assign pend_d    = pend_q + CW'(send_fire) - CW'(ack_take);

  // next-state process
  always_comb begin
    st_d   = st_q;
    wr_d   = wr_q;
    id_d   = id_q;
    blk_d  = blk_q;
    mask_d = mask_q;
    kind_d = kind_q;
    rcl_d  = rcl_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          wr_d  = req_write;
          id_d  = req_id;
          blk_d = req_blk;
          st_d  = ST_LOOK;
        end
      end
      ST_LOOK: begin
        mask_d = tgt;
        if (!e_dirty)  kind_d = MSG_INV;
        else if (wr_q) kind_d = MSG_RCL_INV;
        else           kind_d = MSG_RCL_SHR;
        rcl_d = e_dirty && (tgt != '0);
        st_d  = (tgt == '0) ? ST_REPLY : ST_SEND;
      end
      ST_SEND: begin
        if (send_fire) begin
          mask_d = rest;
          if (rest == '0) st_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (pend_q == '0) st_d = ST_REPLY;
      end
      ST_REPLY: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  // transaction context registers
  always_ff @(posedge clk) begin
    wr_q   <= wr_d;
    id_q   <= id_d;
    blk_q  <= blk_d;
    mask_q <= mask_d;
    kind_q <= kind_d;
    rcl_q  <= rcl_d;
  end

  // entry update on reply, writeback on recall acknowledgement
  assign ent_we    = (st_q == ST_REPLY);
  assign new_pres  = wr_q ? reqbit : (e_pres | reqbit);
  assign new_dirty = wr_q ? 1'b1 : (rcl_q ? 1'b0 : e_dirty);
  assign dat_we    = ack_take && rcl_q;

  assign req_ready = (st_q == ST_IDLE);
  assign msg_valid = (st_q == ST_SEND) && pk_any;
  assign msg_kind  = kind_q;
  assign msg_dst   = pk_idx;
  assign msg_blk   = blk_q;
  assign rsp_valid = (st_q == ST_REPLY);
  assign rsp_dst   = id_q;
  assign rsp_grant = wr_q;
  assign rsp_data  = e_data;

  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dst) && $stable(msg_kind)));

  a_r9_ascending_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> (!msg_valid || (msg_dst > $past(msg_dst))));

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid || rsp_valid) |-> !req_ready);

  a_r8_ready_after_reply: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);

  a_r7_acks_drained: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (pend_q == '0));
endmodule

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb;
  localparam int N  = 4;
  localparam int NB = 8;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_ready;
  logic [IW-1:0] req_id;
  logic [BW-1:0] req_blk;
  logic msg_valid, msg_ready;
  logic [1:0] msg_kind;
  logic [IW-1:0] msg_dst;
  logic [BW-1:0] msg_blk;
  logic ack_valid;
  logic [DW-1:0] ack_data;
  logic rsp_valid, rsp_grant;
  logic [IW-1:0] rsp_dst;
  logic [DW-1:0] rsp_data;

  always #2 clk = ~clk;

  dir_home_ctrl #(.NPROC(N), .NBLK(NB), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_id(req_id), .req_blk(req_blk),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_dst(msg_dst), .msg_blk(msg_blk),
    .ack_valid(ack_valid), .ack_data(ack_data),
    .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_grant(rsp_grant), .rsp_data(rsp_data)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int txn = 0;
  int rsp_seen = 0;
  int pend_b = 0;

  logic [N-1:0]  m_pres [NB];
  logic          m_dirty[NB];
  logic [DW-1:0] m_mem  [NB];

  logic [IW+BW+1:0]  exp_msg[$];
  logic [IW+BW+1:0]  ack_q[$];
  logic [IW+DW:0]    exp_rsp[$];
  string             exp_req[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wb_val(input int b, input int d, input int t);
    return DW'(((t * 37) + (b * 5) + d) ^ 16'h5A00);
  endfunction

  // driver: predicts messages and reply, pushes them, then issues the request
  task automatic do_req(input bit wr, input int id, input int b, input string req);
    logic [N-1:0] reqb, tgt;
    logic [1:0]   kind;
    logic [DW-1:0] d;
    bit rcl;
    int owner;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    txn++;
    reqb = N'(1) << id;
    tgt  = (wr || m_dirty[b]) ? (m_pres[b] & ~reqb) : '0;
    kind = !m_dirty[b] ? 2'd0 : (wr ? 2'd2 : 2'd1);
    rcl  = m_dirty[b] && (tgt != '0);
    owner = 0;
    for (int i = 0; i < N; i++) begin
      if (tgt[i]) begin
        exp_msg.push_back({IW'(i), BW'(b), kind});
        owner = i;
      end
    end
    if (rcl) begin
      d = wb_val(b, owner, txn);
      m_mem[b] = d;
    end else begin
      d = m_mem[b];
    end
    exp_rsp.push_back({IW'(id), wr, d});
    exp_req.push_back(req);
    if (wr) begin
      m_pres[b]  = reqb;
      m_dirty[b] = 1'b1;
    end else begin
      m_pres[b] = m_pres[b] | reqb;
      if (rcl) m_dirty[b] = 1'b0;
    end
    req_valid = 1'b1;
    req_write = wr;
    req_id    = IW'(id);
    req_blk   = BW'(b);
    @(negedge clk);
    req_valid = 1'b0;
    while (rsp_seen < txn) @(negedge clk);
  endtask

  // responder and monitor
  initial begin
    logic [IW+BW+1:0] m, e;
    logic [IW+DW:0]   r;
    string            rq;
    msg_ready = 1'b1;
    ack_valid = 1'b0;
    ack_data  = '0;
    forever begin
      @(negedge clk);
      cyc++;
      msg_ready = ((cyc % 5) != 3);
      if (ack_q.size() > 0 && (cyc % 2) == 0) begin
        m = ack_q.pop_front();
        ack_valid = 1'b1;
        // R10: invalidation acks carry junk that must not be stored
        ack_data = (m[1:0] != 2'd0) ? wb_val(int'(m[BW+1:2]), int'(m[IW+BW+1:BW+2]), txn)
                                     : 16'hDEAD;
        pend_b--;
      end else begin
        ack_valid = 1'b0;
      end
      #1;
      if (rst_n) begin
        if (msg_valid && msg_ready) begin
          m = {msg_dst, msg_blk, msg_kind};
          if (exp_msg.size() == 0) begin
            chk(1'b0, "R9", "unexpected message", longint'(m), 0);
          end else begin
            e = exp_msg.pop_front();
            chk(m == e, "R3/R4/R5/R9", "message {dst,blk,kind}", longint'(m), longint'(e));
          end
          chk(!req_ready, "R8", "ready while sending", longint'(req_ready), 0);
          ack_q.push_back(m);
          pend_b++;
        end
        if (rsp_valid) begin
          rq = (exp_req.size() > 0) ? exp_req.pop_front() : "R2";
          if (exp_rsp.size() == 0) begin
            chk(1'b0, "R11", "unexpected reply", 0, 0);
          end else begin
            r = exp_rsp.pop_front();
            chk(rsp_dst == r[IW+DW:DW+1], "R11", "rsp_dst", longint'(rsp_dst), longint'(r[IW+DW:DW+1]));
            chk(rsp_grant == r[DW], "R11", "rsp_grant", longint'(rsp_grant), longint'(r[DW]));
            chk(rsp_data == r[DW-1:0], rq, "rsp_data", longint'(rsp_data), longint'(r[DW-1:0]));
          end
          chk(pend_b == 0 && ack_q.size() == 0, "R7", "reply before acks", longint'(pend_b), 0);
          chk(!req_ready, "R8", "ready in reply cycle", longint'(req_ready), 0);
          rsp_seen++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_id = '0;
    req_blk = '0;
    for (int b = 0; b < NB; b++) begin
      m_pres[b] = '0;
      m_dirty[b] = 1'b0;
      m_mem[b] = DW'(b);
    end
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R1", "req_ready in reset", longint'(req_ready), 1);
    chk(msg_valid == 1'b0, "R1", "msg_valid in reset", longint'(msg_valid), 0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", longint'(rsp_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    do_req(1'b0, 0, 5, "R1");   // reset data of block 5, clean read R2
    do_req(1'b0, 2, 5, "R2");
    do_req(1'b0, 3, 5, "R2");
    do_req(1'b1, 2, 5, "R4");   // invalidates 0 and 3, not the requester
    do_req(1'b0, 1, 5, "R3");   // recall keep-shared from 2
    do_req(1'b1, 3, 5, "R4");   // invalidates 1 and 2 with junk acks
    do_req(1'b0, 3, 5, "R10");  // owner read, data must be the recalled value
    do_req(1'b1, 1, 5, "R5");   // recall-invalidate from 3
    do_req(1'b1, 1, 5, "R6");   // owner write again, no messages
    do_req(1'b1, 3, 0, "R4");   // clean, no sharers
    for (int i = 0; i < N; i++) do_req(1'b0, i, 7, "R2");
    do_req(1'b1, 0, 7, "R9");   // three invalidations under stalls
    do_req(1'b0, 2, 7, "R3");

    seed = 13;
    for (int k = 0; k < 80; k++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      do_req(seed[20], (seed >> 8) % N, (seed >> 12) % 3, "R2");
    end

    repeat (10) @(negedge clk);
    chk(exp_msg.size() == 0, "R9", "messages left unsent", longint'(exp_msg.size()), 0);
    chk(exp_rsp.size() == 0, "R11", "replies left", longint'(exp_rsp.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule